// File: doc/BRIEF.md
# PHY Trim Field Loader

This block programs a short list of trim fields into the internal 8-bit registers of a serial PHY once the surrounding logic asks for it. The PHY's registers are not memory mapped. They are reached only through a narrow test port, which has one registered 14-bit command word going out and one 8-bit readback value coming in. Each command needs time to settle, so the loader waits out two readback samples after every command it drives.

For every entry of a built-in parameter table, the loader reads the target register and clears the named bit range. It inserts the new field value, keeps every other bit as it was, and writes the result back with a three-command strobe. A dummy read of the same register closes the entry. Two table variants are built in, and a variant input selects between them when the run starts. A legacy input makes the loader skip all programming. In that case it reports completion on the next cycle without touching the port.

Top module: `trim_seq`

## Requirements
- R1: The command word places the 8-bit data in bits 13:6, the 5-bit register number in bits 5:1 and the write strobe in bit 0.
- R2: A register read drives a command with data 1, the register number and strobe 0. The loader takes the register value from the low 8 bits of the readback on the third readback sample after that command appears, which is the third clock edge after it changes.
- R3: Every command word stays unchanged for at least the two clock cycles after it appears. The two readback samples taken in those cycles are discarded.
- R4: The written value equals the value read with bits msb..lsb replaced by the low bits of the entry value. All other bits of the register and all registers outside the table stay unchanged.
- R5: A write consists of three commands with the same register number and data, with strobe values 0, then 1, then 0. The strobe stays high for exactly three cycles.
- R6: Three cycles after the strobe falls, a read command (data 1, strobe 0) for the same register is driven. One readback sample after its two settle samples completes the entry.
- R7: Entries are applied in table order. Variant 0 writes register 7 bits 3:0 = 10, register 8 bits 3:0 = 3, register 9 bits 3:0 = 5, register 11 bits 3:0 = 9, register 13 bits 6:5 = 2, register 27 bits 2:0 = 7 and register 28 bits 1:0 = 1. Variant 1 writes register 7 bits 3:0 = 6, register 13 bits 6:5 = 2 and register 26 bits 7:4 = 5.
- R8: For a non-legacy run, busy is high from the cycle after start is sampled until completion. Done is a single-cycle pulse, with busy low, arriving 17 cycles per entry after the start edge.
- R9: With legacy set at start, the loader drives no command change and no strobe, and the done pulse appears in the cycle right after the start edge.
- R10: A start request while a run is in progress is ignored. The run finishes unchanged and no second run follows.
- R11: During and right after reset, the command word is 0 and busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a run when idle |
| variant_i | input | 1 | Table variant, latched at start |
| legacy_i | input | 1 | Skip programming for this run |
| cmd_o | output | 14 | Registered command word to the PHY test port |
| rdback_i | input | 8 | Readback value from the PHY test port |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bound checker watches the command word on every cycle. It checks the two-cycle hold after each change, the unchanged address and data around the rising and falling strobe, the three-cycle strobe width, and the dummy read three cycles after the strobe falls. It also checks the quiet port while idle and that done is a single pulse with busy low. Whether the loader samples the readback on the correct edge, whether the merge preserves the neighbouring bits, and whether the table contents and order are right can only be shown by the bench's scenarios. For these, a PHY register model returns a poison value during the settle window, and the bench compares all 32 registers and the write order against expectations.

// File: rtl/trim_pkg.sv
package trim_pkg;

    localparam int DATA_W         = 8;
    localparam int ADDR_W         = 5;
    localparam int CMD_W          = DATA_W + ADDR_W + 1;
    localparam int FPOS_W         = $clog2(DATA_W);
    localparam int MAX_ENTRIES    = 7;
    localparam int IDX_W          = $clog2(MAX_ENTRIES + 1);
    localparam int NUM_VARIANTS   = 2;
    localparam int VSEL_W         = 1;
    localparam int SETTLE_SAMPLES = 2;

    typedef struct packed {
        logic [ADDR_W-1:0] reg_no;
        logic [FPOS_W-1:0] msb;
        logic [FPOS_W-1:0] lsb;
        logic [DATA_W-1:0] value;
    } trim_entry_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ISSUE,
        S_SETTLE,
        S_SAMPLE
    } seq_state_e;

    typedef enum logic [2:0] {
        ST_READ,
        ST_WR_PRE,
        ST_WR_STROBE,
        ST_WR_POST,
        ST_DUMMY
    } step_e;

    function automatic trim_entry_t mk_entry(int r, int m, int l, int v);
        trim_entry_t e;
        e.reg_no = ADDR_W'(r);
        e.msb    = FPOS_W'(m);
        e.lsb    = FPOS_W'(l);
        e.value  = DATA_W'(v);
        return e;
    endfunction

    // Command word: data in the top byte, register number below, strobe in bit 0.
    function automatic logic [CMD_W-1:0] make_cmd(logic [DATA_W-1:0] data,
                                                  logic [ADDR_W-1:0] addr,
                                                  logic              we);
        return {data, addr, we};
    endfunction

    function automatic logic [DATA_W-1:0] field_mask(logic [FPOS_W-1:0] msb,
                                                     logic [FPOS_W-1:0] lsb);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < DATA_W; i++) begin
            m[i] = (FPOS_W'(i) >= lsb) && (FPOS_W'(i) <= msb);
        end
        return m;
    endfunction

    function automatic trim_entry_t table_entry(logic [VSEL_W-1:0] v,
                                                logic [IDX_W-1:0]  i);
        trim_entry_t e;
        e = mk_entry(0, 0, 0, 0);
        if (v == VSEL_W'(0)) begin
            case (i)
                IDX_W'(0): e = mk_entry(7,  3, 0, 10);
                IDX_W'(1): e = mk_entry(8,  3, 0, 3);
                IDX_W'(2): e = mk_entry(9,  3, 0, 5);
                IDX_W'(3): e = mk_entry(11, 3, 0, 9);
                IDX_W'(4): e = mk_entry(13, 6, 5, 2);
                IDX_W'(5): e = mk_entry(27, 2, 0, 7);
                IDX_W'(6): e = mk_entry(28, 1, 0, 1);
                default:   e = mk_entry(0, 0, 0, 0);
            endcase
        end else begin
            case (i)
                IDX_W'(0): e = mk_entry(7,  3, 0, 6);
                IDX_W'(1): e = mk_entry(13, 6, 5, 2);
                IDX_W'(2): e = mk_entry(26, 7, 4, 5);
                default:   e = mk_entry(0, 0, 0, 0);
            endcase
        end
        return e;
    endfunction

    function automatic logic [IDX_W-1:0] table_len(logic [VSEL_W-1:0] v);
        return (v == VSEL_W'(0)) ? IDX_W'(7) : IDX_W'(3);
    endfunction

endpackage

// File: rtl/trim_rom.sv
module trim_rom
    import trim_pkg::*;
#(
    parameter int VARIANTS = NUM_VARIANTS
) (
    input  logic [VSEL_W-1:0] variant_i,
    input  logic [IDX_W-1:0]  idx_i,
    output trim_entry_t       entry_o,
    output logic [IDX_W-1:0]  len_o
);

    trim_entry_t      ent_v [VARIANTS];
    logic [IDX_W-1:0] len_v [VARIANTS];

    for (genvar gv = 0; gv < VARIANTS; gv++) begin : g_variant
        assign ent_v[gv] = table_entry(VSEL_W'(gv), idx_i);
        assign len_v[gv] = table_len(VSEL_W'(gv));
    end

    assign entry_o = ent_v[variant_i];
    assign len_o   = len_v[variant_i];

endmodule

// File: rtl/trim_merge.sv
module trim_merge
    import trim_pkg::*;
(
    input  logic [DATA_W-1:0] old_i,
    input  logic [FPOS_W-1:0] msb_i,
    input  logic [FPOS_W-1:0] lsb_i,
    input  logic [DATA_W-1:0] value_i,
    output logic [DATA_W-1:0] new_o
);

    logic [DATA_W-1:0] mask;

    always_comb begin
        mask  = field_mask(msb_i, lsb_i);
        new_o = (old_i & ~mask) | ((value_i << lsb_i) & mask);
    end

endmodule

// File: rtl/trim_ctrl.sv
module trim_ctrl
    import trim_pkg::*;
#(
    parameter int SETTLE = SETTLE_SAMPLES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [VSEL_W-1:0] variant_i,
    input  logic              legacy_i,
    input  logic [IDX_W-1:0]  len_i,
    input  logic [ADDR_W-1:0] reg_no_i,
    input  logic [DATA_W-1:0] new_val_i,
    input  logic [DATA_W-1:0] rdback_i,
    output logic [VSEL_W-1:0] variant_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [DATA_W-1:0] old_val_o,
    output logic [CMD_W-1:0]  cmd_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam int CNT_W = $clog2(SETTLE + 1);

    seq_state_e        state_q;
    step_e             step_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] old_q;
    logic [CMD_W-1:0]  cmd_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [VSEL_W-1:0] variant_q;
    logic              done_q;
    logic [CMD_W-1:0]  cmd_next;

    always_comb begin
        unique case (step_q)
            ST_WR_PRE,
            ST_WR_POST:   cmd_next = make_cmd(new_val_i, reg_no_i, 1'b0);
            ST_WR_STROBE: cmd_next = make_cmd(new_val_i, reg_no_i, 1'b1);
            default:      cmd_next = make_cmd(DATA_W'(1), reg_no_i, 1'b0);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_IDLE;
            step_q    <= ST_READ;
            idx_q     <= '0;
            old_q     <= '0;
            cmd_q     <= '0;
            cnt_q     <= '0;
            variant_q <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        variant_q <= variant_i;
                        if (legacy_i) begin
                            done_q <= 1'b1;
                        end else begin
                            idx_q   <= '0;
                            step_q  <= ST_READ;
                            state_q <= S_ISSUE;
                        end
                    end
                end
                S_ISSUE: begin
                    cmd_q   <= cmd_next;
                    cnt_q   <= '0;
                    state_q <= S_SETTLE;
                end
                S_SETTLE: begin
                    if (cnt_q == CNT_W'(SETTLE - 1)) begin
                        unique case (step_q)
                            ST_WR_PRE: begin
                                step_q  <= ST_WR_STROBE;
                                state_q <= S_ISSUE;
                            end
                            ST_WR_STROBE: begin
                                step_q  <= ST_WR_POST;
                                state_q <= S_ISSUE;
                            end
                            ST_WR_POST: begin
                                step_q  <= ST_DUMMY;
                                state_q <= S_ISSUE;
                            end
                            default: state_q <= S_SAMPLE;
                        endcase
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                S_SAMPLE: begin
                    if (step_q == ST_READ) begin
                        old_q   <= rdback_i;
                        step_q  <= ST_WR_PRE;
                        state_q <= S_ISSUE;
                    end else if (idx_q == len_i - IDX_W'(1)) begin
                        done_q  <= 1'b1;
                        state_q <= S_IDLE;
                    end else begin
                        idx_q   <= idx_q + IDX_W'(1);
                        step_q  <= ST_READ;
                        state_q <= S_ISSUE;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign variant_o = variant_q;
    assign idx_o     = idx_q;
    assign old_val_o = old_q;
    assign cmd_o     = cmd_q;
    assign busy_o    = (state_q != S_IDLE);
    assign done_o    = done_q;

endmodule

// File: rtl/trim_seq.sv
module trim_seq
    import trim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              variant_i,
    input  logic              legacy_i,
    output logic [CMD_W-1:0]  cmd_o,
    input  logic [DATA_W-1:0] rdback_i,
    output logic              busy_o,
    output logic              done_o
);

    trim_entry_t       entry;
    logic [IDX_W-1:0]  len;
    logic [IDX_W-1:0]  idx;
    logic [VSEL_W-1:0] variant_q;
    logic [DATA_W-1:0] old_val;
    logic [DATA_W-1:0] new_val;

    trim_rom #(.VARIANTS(NUM_VARIANTS)) u_rom (
        .variant_i (variant_q),
        .idx_i     (idx),
        .entry_o   (entry),
        .len_o     (len)
    );

    trim_merge u_merge (
        .old_i   (old_val),
        .msb_i   (entry.msb),
        .lsb_i   (entry.lsb),
        .value_i (entry.value),
        .new_o   (new_val)
    );

    trim_ctrl #(.SETTLE(SETTLE_SAMPLES)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .variant_i (variant_i),
        .legacy_i  (legacy_i),
        .len_i     (len),
        .reg_no_i  (entry.reg_no),
        .new_val_i (new_val),
        .rdback_i  (rdback_i),
        .variant_o (variant_q),
        .idx_o     (idx),
        .old_val_o (old_val),
        .cmd_o     (cmd_o),
        .busy_o    (busy_o),
        .done_o    (done_o)
    );

endmodule

// File: rtl/trim_seq_chk.sv
module trim_seq_chk
    import trim_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [CMD_W-1:0] cmd,
    input logic             busy,
    input logic             done
);

    // R3: a new command word is held for the two following cycles
    p_hold_first_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd != $past(cmd)) |=> $stable(cmd));
    p_hold_second_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd != $past(cmd)) |-> ##2 $stable(cmd));

    // R5: strobe rises and falls with unchanged data and address, high three cycles
    p_strobe_pre_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd[0]) |-> (cmd[CMD_W-1:1] == $past(cmd[CMD_W-1:1])));
    p_strobe_post_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(cmd[0]) |-> (cmd[CMD_W-1:1] == $past(cmd[CMD_W-1:1])));
    p_strobe_len_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd[0]) |-> ##3 !cmd[0]);

    // R6: dummy read of the same register three cycles after the strobe falls
    p_dummy_read_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(cmd[0]) |-> ##3 (cmd[CMD_W-1:ADDR_W+1] == DATA_W'(1) &&
                               cmd[ADDR_W:1] == $past(cmd[ADDR_W:1], 3) &&
                               !cmd[0]));

    // R8: done is a single pulse with busy low
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R9: idle port is quiet
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy)) |-> ($stable(cmd) && !cmd[0]));

endmodule

bind trim_seq trim_seq_chk u_chk (
    .clk  (clk),
    .rst  (rst),
    .cmd  (cmd_o),
    .busy (busy_o),
    .done (done_o)
);

// File: tb/sim_trim_seq.sv
module sim_trim_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        variant = 1'b0;
    logic        legacy = 1'b0;
    logic [13:0] cmd;
    logic [7:0]  rdback;
    logic        busy;
    logic        done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    trim_seq u0 (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start),
        .variant_i (variant),
        .legacy_i  (legacy),
        .cmd_o     (cmd),
        .rdback_i  (rdback),
        .busy_o    (busy),
        .done_o    (done)
    );

    // ---------------- PHY register model ----------------
    logic [7:0]  phy_regs [32];
    logic [13:0] last_cmd;
    logic [1:0]  age;
    logic        load_req = 1'b0;
    logic [7:0]  load_seed = 8'h00;
    logic        mon_clr = 1'b0;

    function automatic logic [7:0] pat(int i, logic [7:0] s);
        return 8'((i * 37) ^ s) + 8'h13;
    endfunction

    // poison value during the two settle samples after a command change
    assign rdback = ((cmd != last_cmd) || (age == 2'd0)) ? 8'h5A : phy_regs[cmd[5:1]];

    // monitors
    int  done_cnt, pulse_err, wr_n, cmd_changes;
    int  wr_addr [16];
    logic done_prev;

    always @(posedge clk) begin
        if (rst) begin
            last_cmd <= '0;
            age      <= 2'd3;
        end else begin
            last_cmd <= cmd;
            if (cmd != last_cmd) age <= 2'd0;
            else if (age != 2'd3) age <= age + 2'd1;
        end
        if (load_req) begin
            for (int i = 0; i < 32; i++) phy_regs[i] <= pat(i, load_seed);
        end else if (!rst && cmd[0]) begin
            phy_regs[cmd[5:1]] <= cmd[13:6];
        end
        if (mon_clr || rst) begin
            done_cnt <= 0; pulse_err <= 0; wr_n <= 0; cmd_changes <= 0; done_prev <= 1'b0;
        end else begin
            done_prev <= done;
            if (done) done_cnt <= done_cnt + 1;
            if (done && done_prev) pulse_err <= pulse_err + 1;
            if (cmd != last_cmd) cmd_changes <= cmd_changes + 1;
            if (cmd[0] && !last_cmd[0]) begin
                if (wr_n < 16) wr_addr[wr_n] <= int'(cmd[5:1]);
                wr_n <= wr_n + 1;
            end
        end
    end

    // ---------------- expected table (from the requirements) ----------------
    localparam int E_REG [0:9] = '{7, 8, 9, 11, 13, 27, 28, 7, 13, 26};
    localparam int E_MSB [0:9] = '{3, 3, 3, 3, 6, 2, 1, 3, 6, 7};
    localparam int E_LSB [0:9] = '{0, 0, 0, 0, 5, 0, 0, 0, 5, 4};
    localparam int E_VAL [0:9] = '{10, 3, 5, 9, 2, 7, 1, 6, 2, 5};

    // scenario vectors: {variant, legacy, seed}
    localparam logic [9:0] SCEN [0:4] = '{
        {1'b0, 1'b0, 8'h3C},
        {1'b1, 1'b0, 8'hA7},
        {1'b0, 1'b1, 8'h55},
        {1'b1, 1'b1, 8'h00},
        {1'b0, 1'b0, 8'hFF}
    };

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_scen(logic v, logic l, logic [7:0] s, bit extra_start);
        logic [7:0] exp_regs [32];
        int base, n, cyc, lat;
        load_seed = s;
        load_req  = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
        mon_clr  = 1'b1;
        @(negedge clk);
        mon_clr  = 1'b0;
        for (int i = 0; i < 32; i++) exp_regs[i] = pat(i, s);
        base = v ? 7 : 0;
        n    = v ? 3 : 7;
        if (!l) begin
            for (int e = base; e < base + n; e++) begin
                for (int b = E_LSB[e]; b <= E_MSB[e]; b++)
                    exp_regs[E_REG[e]][b] = E_VAL[e][b - E_LSB[e]];
            end
        end
        variant = v;
        legacy  = l;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc   = 1;
        check(busy == !l, l ? "R9 busy stays low" : "R8 busy after start", int'(busy), int'(!l));
        while (!done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            if (extra_start && cyc == 5) begin
                start = 1'b1; variant = ~v; legacy = 1'b0;
            end else begin
                start = 1'b0;
            end
        end
        lat = l ? 1 : 17 * n + 1;
        check(cyc == lat, l ? "R9 done latency" : "R8 done latency", cyc, lat);
        check(busy == 1'b0, "R8 busy low with done", int'(busy), 0);
        repeat (30) @(negedge clk);
        check(done_cnt == 1, "R8 one done pulse", done_cnt, 1);
        check(pulse_err == 0, "R8 done width", pulse_err, 0);
        check(busy == 1'b0, "R10 no further run", int'(busy), 0);
        check(wr_n == (l ? 0 : n), "R5 strobe count", wr_n, l ? 0 : n);
        if (l) check(cmd_changes == 0, "R9 port quiet", cmd_changes, 0);
        else begin
            for (int e = 0; e < n && e < 16; e++)
                check(wr_addr[e] == E_REG[base + e], "R7 write order", wr_addr[e], E_REG[base + e]);
        end
        for (int i = 0; i < 32; i++)
            check(phy_regs[i] == exp_regs[i], "R4 register contents (R1 R2 R3)", int'(phy_regs[i]), int'(exp_regs[i]));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R11: reset state
        check(cmd == 14'd0, "R11 cmd in reset", int'(cmd), 0);
        check(busy == 1'b0, "R11 busy in reset", int'(busy), 0);
        check(done == 1'b0, "R11 done in reset", int'(done), 0);
        rst = 1'b0;
        @(negedge clk);
        check(cmd == 14'd0 && !busy && !done, "R11 after reset", int'(cmd), 0);

        for (int k = 0; k < 5; k++) begin
            run_scen(SCEN[k][9], SCEN[k][8], SCEN[k][7:0], 1'b0);
        end

        // R10: second start during a variant 1 run is ignored
        run_scen(1'b1, 1'b0, 8'h6E, 1'b1);

        // R6: back-to-back runs still complete cleanly
        run_scen(1'b0, 1'b0, 8'h81, 1'b0);

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule